// File: doc/BRIEF.md
# Iterative Divide and Square-Root Coprocessor

This block is a register-mapped arithmetic helper that sits on a simple synchronous slave port. Software loads a dividend and a divisor, picks signed or unsigned arithmetic and whether it wants the quotient or the remainder, and then starts the operation. Writing a radicand starts an integer square root instead. A busy flag shows when the work is in progress. The answer appears in the result register once busy falls.

A divide can start in two ways, chosen by a control bit. With the default quick-launch mode, the divisor write itself starts the divide. With quick launch turned off, software has to write the control word with its go bit set. When the divisor is zero, the divide completes in the same cycle and sets a sticky zero-divisor flag. If an optional enable is set, the flag turns a result read into an error response instead of returning data.

Top module: `divsqrt_unit`

## Requirements
- R1: After reset, every register reads as zero, including the control/status word (offset 0x08), and bus_err is low.
- R2: The byte offsets are 0x00 dividend, 0x04 divisor, 0x08 control/status, 0x0C result and 0x10 radicand. Dividend, divisor and result read back what was written while the unit is idle. The radicand reads as zero. In the control/status word, bits 1, 2, 3 and 5 read back as written, and bit 0 always reads as zero.
- R3: While control bit 5 is 0, a divisor write starts a divide using the stored control bits. A control write with bit 0 set starts nothing.
- R4: While control bit 5 is 1, a divisor write starts nothing. A control write that has both bit 0 and bit 5 set starts a divide, and that divide uses bits 1 and 2 of the same write.
- R5: With control bit 1 = 1, the divide is unsigned. Control bit 2 = 0 puts the quotient in the result register and bit 2 = 1 puts the remainder there.
- R6: With control bit 1 = 0, the divide is two's-complement. The quotient is truncated toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A divide with a zero divisor never raises busy. It sets status bit 4 and writes all ones (quotient) or the dividend (remainder) to the result register. A divide with a non-zero divisor clears bit 4.
- R8: A result read returns bus_err = 1 and data 0 when control bit 3 and status bit 4 are both 1. Every other read returns bus_err = 0 with the register contents.
- R9: A radicand write starts an unsigned integer square root. The result register then receives the floor of the square root, zero-extended.
- R10: Status bit 31 (busy) is high for exactly 33 cycles for a divide and 16 cycles for a square root, counted from the cycle after the starting write. At start, bit 30 (divide) and bit 29 (square root) are set one-hot, and they keep their values after the operation ends.
- R11: A start request made while busy is ignored. This covers divisor, control and radicand writes. The running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Error response for the current read |

## Verification
The properties assume that each cycle carries at most one strobe. They also assume the address is one of the five defined offsets, and that the reset value of the quick-launch bit is not changed by a write that also starts an operation through the divisor port. The bench keeps to these assumptions: its access tasks issue exactly one read or one write per cycle, always at a listed offset. Random operands come from a fixed-seed generator, and every random divide forces its divisor to be non-zero. Zero divisors, the error response and start requests made while busy appear only in directed sequences, where the mode bits are set on purpose.

// File: rtl/divsqrt_pkg.sv
package divsqrt_pkg;
   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] OFS_DVD = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DVS = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CTL = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_RES = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_RAD = 5'h10;
   // control/status bit positions, fixed because software decodes them
   localparam int BIT_GO   = 0;
   localparam int BIT_UNS  = 1;
   localparam int BIT_REM  = 2;
   localparam int BIT_ZEN  = 3;
   localparam int BIT_ZF   = 4;
   localparam int BIT_SLOW = 5;
   localparam int BIT_SQ   = 29;
   localparam int BIT_DV   = 30;
   localparam int BIT_BSY  = 31;
endpackage

// File: rtl/divsqrt_divider.sv
module divsqrt_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         is_uns,
   input  logic         want_rem,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         finish,
   output logic [W-1:0] res
);
   localparam int CW = $clog2(W + 1);

   logic          run;
   logic [CW-1:0] cnt;
   logic [W-1:0]  quo, rem, dvs;
   logic          qneg, rneg, sel;
   logic [W:0]    sh, diff;
   logic          ge;
   logic          num_neg, den_neg;
   logic [W-1:0]  num_mag, den_mag;

   always_comb begin
      num_neg = !is_uns && num[W-1];
      den_neg = !is_uns && den[W-1];
      num_mag = num_neg ? (~num + 1'b1) : num;
      den_mag = den_neg ? (~den + 1'b1) : den;
      sh      = {rem, quo[W-1]};
      diff    = sh - {1'b0, dvs};
      ge      = ~diff[W];
   end

   // last busy cycle is the sign fix-up step
   assign busy   = run;
   assign finish = run && (cnt == CW'(W));
   assign res    = sel ? (rneg ? (~rem + 1'b1) : rem)
                       : (qneg ? (~quo + 1'b1) : quo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         cnt  <= '0;
         quo  <= '0;
         rem  <= '0;
         dvs  <= '0;
         qneg <= 1'b0;
         rneg <= 1'b0;
         sel  <= 1'b0;
      end else if (start) begin
         run  <= 1'b1;
         cnt  <= '0;
         quo  <= num_mag;
         rem  <= '0;
         dvs  <= den_mag;
         qneg <= num_neg ^ den_neg;
         rneg <= num_neg;
         sel  <= want_rem;
      end else if (run) begin
         if (finish) begin
            run <= 1'b0;
         end else begin
            rem <= ge ? diff[W-1:0] : sh[W-1:0];
            quo <= {quo[W-2:0], ge};
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/divsqrt_sqrt.sv
module divsqrt_sqrt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] rad,
   output logic         busy,
   output logic         finish,
   output logic [W-1:0] res
);
   localparam int H  = W / 2;
   localparam int CW = $clog2(H);

   logic          run;
   logic [CW-1:0] cnt;
   logic [W-1:0]  src;
   logic [H:0]    part;
   logic [H-1:0]  root, nxt_root;
   logic [H+2:0]  cur, trial, diff;
   logic          ge;

   always_comb begin
      cur      = {part, src[W-1:W-2]};
      trial    = {1'b0, root, 2'b01};
      diff     = cur - trial;
      ge       = ~diff[H+2];
      nxt_root = {root[H-2:0], ge};
   end

   assign busy   = run;
   assign finish = run && (cnt == CW'(H - 1));
   assign res    = {{(W-H){1'b0}}, nxt_root};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         cnt  <= '0;
         src  <= '0;
         part <= '0;
         root <= '0;
      end else if (start) begin
         run  <= 1'b1;
         cnt  <= '0;
         src  <= rad;
         part <= '0;
         root <= '0;
      end else if (run) begin
         src  <= {src[W-3:0], 2'b00};
         part <= ge ? diff[H:0] : cur[H:0];
         root <= nxt_root;
         cnt  <= cnt + 1'b1;
         if (finish) run <= 1'b0;
      end
   end
endmodule

// File: rtl/divsqrt_unit.sv
module divsqrt_unit
   import divsqrt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err
);
   generate
      if (DATA_W < 32 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("divsqrt_unit: DATA_W must be even and at least 32");
      end
   endgenerate

   logic [DATA_W-1:0] dvd_q, dvs_q, res_q;
   logic uns_q, rem_q, zen_q, slow_q, zf_q, op_div_q, op_sq_q;
   logic div_busy, div_fin, sq_busy, sq_fin, busy;
   logic [DATA_W-1:0] div_res, sq_res, den, csr_view;
   logic hit_dvd, hit_dvs, hit_ctl, hit_res, hit_rad;
   logic ctl_go, div_go, core_go, sq_go, den_zero, go_uns, go_rem;

   always_comb begin
      hit_dvd  = bus_addr == OFS_DVD;
      hit_dvs  = bus_addr == OFS_DVS;
      hit_ctl  = bus_addr == OFS_CTL;
      hit_res  = bus_addr == OFS_RES;
      hit_rad  = bus_addr == OFS_RAD;
      busy     = div_busy | sq_busy;
      ctl_go   = bus_wr && hit_ctl && bus_wdata[BIT_GO] && bus_wdata[BIT_SLOW];
      div_go   = !busy && ((bus_wr && hit_dvs && !slow_q) || ctl_go);
      go_uns   = ctl_go ? bus_wdata[BIT_UNS] : uns_q;
      go_rem   = ctl_go ? bus_wdata[BIT_REM] : rem_q;
      den      = (bus_wr && hit_dvs) ? bus_wdata : dvs_q;
      den_zero = den == '0;
      core_go  = div_go && !den_zero;
      sq_go    = !busy && bus_wr && hit_rad;
   end

   divsqrt_divider #(.W(DATA_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(core_go), .is_uns(go_uns),
      .want_rem(go_rem), .num(dvd_q), .den(den),
      .busy(div_busy), .finish(div_fin), .res(div_res)
   );

   divsqrt_sqrt #(.W(DATA_W)) u_sqrt (
      .clk(clk), .rst_n(rst_n), .start(sq_go), .rad(bus_wdata),
      .busy(sq_busy), .finish(sq_fin), .res(sq_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q    <= '0;
         dvs_q    <= '0;
         res_q    <= '0;
         uns_q    <= 1'b0;
         rem_q    <= 1'b0;
         zen_q    <= 1'b0;
         slow_q   <= 1'b0;
         zf_q     <= 1'b0;
         op_div_q <= 1'b0;
         op_sq_q  <= 1'b0;
      end else begin
         if (bus_wr && hit_dvd) dvd_q <= bus_wdata;
         if (bus_wr && hit_dvs) dvs_q <= bus_wdata;
         if (bus_wr && hit_ctl) begin
            uns_q  <= bus_wdata[BIT_UNS];
            rem_q  <= bus_wdata[BIT_REM];
            zen_q  <= bus_wdata[BIT_ZEN];
            slow_q <= bus_wdata[BIT_SLOW];
         end
         if (div_go) begin
            op_div_q <= 1'b1;
            op_sq_q  <= 1'b0;
            zf_q     <= den_zero;
         end else if (sq_go) begin
            op_div_q <= 1'b0;
            op_sq_q  <= 1'b1;
         end
         if (div_go && den_zero)         res_q <= go_rem ? dvd_q : '1;
         else if (div_fin)               res_q <= div_res;
         else if (sq_fin)                res_q <= sq_res;
         else if (bus_wr && hit_res && !busy) res_q <= bus_wdata;
      end
   end

   always_comb begin
      csr_view           = '0;
      csr_view[BIT_UNS]  = uns_q;
      csr_view[BIT_REM]  = rem_q;
      csr_view[BIT_ZEN]  = zen_q;
      csr_view[BIT_ZF]   = zf_q;
      csr_view[BIT_SLOW] = slow_q;
      csr_view[BIT_SQ]   = op_sq_q;
      csr_view[BIT_DV]   = op_div_q;
      csr_view[BIT_BSY]  = busy;
      bus_err   = bus_rd && hit_res && zen_q && zf_q;
      bus_rdata = '0;
      if (bus_rd && !bus_err) begin
         unique case (1'b1)
            hit_dvd: bus_rdata = dvd_q;
            hit_dvs: bus_rdata = dvs_q;
            hit_ctl: bus_rdata = csr_view;
            hit_res: bus_rdata = res_q;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/divsqrt_chk.sv
module divsqrt_chk
   import divsqrt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_err,
   input logic              busy,
   input logic              op_div,
   input logic              op_sq,
   input logic              zf,
   input logic              slow
);
   localparam int DIV_LEN = DATA_W + 1;
   localparam int SQ_LEN  = DATA_W / 2;
   localparam int CW      = $clog2(DIV_LEN + 2) + 1;

   logic [CW-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_cnt <= '0;
      else if (busy)  run_cnt <= run_cnt + 1'b1;
      else            run_cnt <= '0;
   end

   a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == (op_div ? CW'(DIV_LEN) : CW'(SQ_LEN))));

   a_r10_flag_kind: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (op_div ^ op_sq));

   a_r10_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_div, op_sq}));

   a_r8_err_place: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rd && bus_addr == OFS_RES && zf));

   a_r7_zero_quick: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !slow && bus_wr && bus_addr == OFS_DVS && bus_wdata == '0)
      |=> (!busy && zf && op_div));

   a_r3_quick_go: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !slow && bus_wr && bus_addr == OFS_DVS && bus_wdata != '0)
      |=> (busy && op_div && !zf));

   a_r4_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && slow && bus_wr && bus_addr == OFS_DVS) |=> !busy);

   a_r11_keep_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_div) && $stable(zf)));
endmodule

bind divsqrt_unit divsqrt_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_err(bus_err),
   .busy(busy), .op_div(op_div_q), .op_sq(op_sq_q), .zf(zf_q), .slow(slow_q)
);

// File: tb/test_divsqrt_unit.sv
module test_divsqrt_unit;
   import divsqrt_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              bus_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   divsqrt_unit #(.DATA_W(32)) i_divsqrt_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err)
   );

   function automatic logic [31:0] ref_div(logic [31:0] a, logic [31:0] b,
                                           bit uns, bit rem);
      longint sa, sb, r;
      if (b == 0) return rem ? a : 32'hFFFF_FFFF;
      if (uns) return rem ? (a % b) : (a / b);
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      r  = rem ? (sa % sb) : (sa / sb);
      return r[31:0];
   endfunction

   function automatic logic [31:0] ref_sqrt(logic [31:0] a);
      longint unsigned r = 0;
      for (int k = 15; k >= 0; k--) begin
         longint unsigned t = r | (64'd1 << k);
         if (t * t <= {32'd0, a}) r = t;
      end
      return r[31:0];
   endfunction

   function automatic logic [31:0] ctl_word(bit go, bit uns, bit rem, bit zen, bit slow);
      return (32'(slow) << 5) | (32'(zen) << 3) | (32'(rem) << 2) |
             (32'(uns) << 1) | 32'(go);
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata; e = bus_err;
      #1 bus_rd = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      logic [31:0] v; logic e;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         rd(OFS_CTL, v, e);
         if (!v[BIT_BSY]) break;
         n++;
      end
   endtask

   task automatic run_div(logic [31:0] a, logic [31:0] b, bit uns, bit rem,
                          bit slow, string tag);
      int n; logic [31:0] v; logic e;
      wr(OFS_DVD, a);
      if (!slow) begin
         wr(OFS_CTL, ctl_word(0, uns, rem, 0, 0));
         wr(OFS_DVS, b);
      end else begin
         wr(OFS_CTL, ctl_word(0, 0, 0, 0, 1));
         wr(OFS_DVS, b);
         wr(OFS_CTL, ctl_word(1, uns, rem, 0, 1));
      end
      wait_idle(n);
      chk(n == ((b == 0) ? 0 : 33), "R10 divide busy cycles", 32'(n),
          (b == 0) ? 32'd0 : 32'd33);
      rd(OFS_RES, v, e);
      chk(v == ref_div(a, b, uns, rem) && !e, tag, v, ref_div(a, b, uns, rem));
   endtask

   task automatic run_sqrt(logic [31:0] a);
      int n; logic [31:0] v; logic e;
      wr(OFS_RAD, a);
      wait_idle(n);
      chk(n == 16, "R10 sqrt busy cycles", 32'(n), 32'd16);
      rd(OFS_RES, v, e);
      chk(v == ref_sqrt(a), "R9 sqrt result", v, ref_sqrt(a));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v; logic e; int n;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 4; k++) begin
         rd(ADDR_W'(k * 4), v, e);
         chk(v == 0 && !e, "R1 reset value", v, 0);
      end

      // R2 register read-back with quick launch off
      wr(OFS_CTL, ctl_word(0, 1, 1, 1, 1));
      rd(OFS_CTL, v, e);
      chk(v == 32'h2E, "R2 control read-back", v, 32'h2E);
      wr(OFS_DVD, 32'hA5A5_0F0F);
      rd(OFS_DVD, v, e);
      chk(v == 32'hA5A5_0F0F, "R2 dividend read-back", v, 32'hA5A5_0F0F);
      wr(OFS_DVS, 32'h1234_5678);
      rd(OFS_DVS, v, e);
      chk(v == 32'h1234_5678, "R2 divisor read-back", v, 32'h1234_5678);
      // R4 divisor write in slow mode started nothing
      rd(OFS_CTL, v, e);
      chk(v[BIT_BSY] == 0 && v[BIT_DV] == 0, "R4 divisor write idle", v, 32'h2E);
      wr(OFS_RES, 32'hCAFE_0001);
      rd(OFS_RES, v, e);
      chk(v == 32'hCAFE_0001, "R2 result write", v, 32'hCAFE_0001);
      wr(OFS_RAD, 32'd81);
      wait_idle(n);
      rd(OFS_RAD, v, e);
      chk(v == 0, "R2 radicand reads zero", v, 0);
      rd(OFS_RES, v, e);
      chk(v == 9, "R9 sqrt of 81", v, 9);
      rd(OFS_CTL, v, e);
      chk(v[BIT_SQ] && !v[BIT_DV], "R10 sqrt flags", v, 32'h2000_002E);

      // R3 quick launch: go bit alone starts nothing
      wr(OFS_CTL, ctl_word(0, 1, 0, 0, 0));
      wr(OFS_CTL, ctl_word(1, 1, 0, 0, 0));
      rd(OFS_CTL, v, e);
      chk(!v[BIT_BSY] && v[BIT_SQ], "R3 go bit ignored", v, 32'h2000_0002);
      wr(OFS_DVD, 32'd100);
      wr(OFS_DVS, 32'd7);
      wait_idle(n);
      chk(n == 33, "R3 divisor write starts", 32'(n), 33);
      rd(OFS_RES, v, e);
      chk(v == 14, "R5 unsigned quotient", v, 14);
      rd(OFS_CTL, v, e);
      chk(v[BIT_DV] && !v[BIT_SQ], "R10 divide flags", v, 32'h4000_0002);

      // R4 start bit uses the same write's mode bits
      run_div(32'd100, 32'd7, 1, 1, 1, "R4 slow start remainder");
      run_div(32'hFFFF_FFF9, 32'd2, 0, 0, 1, "R6 -7/2 quotient");
      run_div(32'hFFFF_FFF9, 32'd2, 0, 1, 0, "R6 -7/2 remainder");
      run_div(32'd7, 32'hFFFF_FFFE, 0, 0, 0, "R6 7/-2 quotient");
      run_div(32'd7, 32'hFFFF_FFFE, 0, 1, 0, "R6 7/-2 remainder");
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R6 min by -1 quotient");
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, "R6 min by -1 remainder");
      run_div(32'hFFFF_FFFF, 32'd1, 1, 0, 0, "R5 max by one");

      // R7 zero divisor
      run_div(32'd1234, 32'd0, 0, 0, 0, "R7 zero divisor quotient");
      run_div(32'd1234, 32'd0, 1, 1, 1, "R7 zero divisor remainder");
      rd(OFS_CTL, v, e);
      chk(v[BIT_ZF] == 1, "R7 zero flag set", v, 32'h4000_0036);
      // R8 error response
      wr(OFS_CTL, ctl_word(0, 1, 1, 1, 1));
      rd(OFS_RES, v, e);
      chk(e == 1 && v == 0, "R8 result read errors", {31'd0, e}, 1);
      rd(OFS_DVD, v, e);
      chk(e == 0 && v == 1234, "R8 other read clean", v, 1234);
      wr(OFS_CTL, ctl_word(0, 1, 1, 0, 1));
      rd(OFS_RES, v, e);
      chk(e == 0 && v == 1234, "R8 enable clear gives data", v, 1234);
      wr(OFS_CTL, ctl_word(0, 1, 1, 1, 0));
      wr(OFS_DVS, 32'd5);
      wait_idle(n);
      rd(OFS_RES, v, e);
      chk(e == 0 && v == 4, "R7 nonzero clears flag", v, 4);
      rd(OFS_CTL, v, e);
      chk(v[BIT_ZF] == 0, "R7 flag clear", v, 32'h4000_000E);

      // R11 start requests while busy
      wr(OFS_CTL, ctl_word(0, 1, 0, 0, 0));
      wr(OFS_DVD, 32'd1000);
      wr(OFS_DVS, 32'd10);
      wr(OFS_RAD, 32'd49);
      wr(OFS_DVS, 32'd0);
      wait_idle(n);
      rd(OFS_RES, v, e);
      chk(v == 100, "R11 busy starts ignored", v, 100);
      rd(OFS_CTL, v, e);
      chk(v[BIT_DV] && !v[BIT_SQ] && !v[BIT_ZF], "R11 flags kept", v, 32'h4000_0002);

      // R9 square-root corners
      run_sqrt(32'd0);
      run_sqrt(32'd1);
      run_sqrt(32'd15);
      run_sqrt(32'd16);
      run_sqrt(32'hFFFF_FFFF);

      // random mix
      for (int k = 0; k < 120; k++) begin
         logic [31:0] a, b; bit uns, rem, slow; int pick;
         a = $urandom; b = $urandom; pick = $urandom_range(0, 3);
         uns = $urandom_range(0, 1); rem = $urandom_range(0, 1);
         slow = $urandom_range(0, 1);
         if (pick == 0) b = b >> $urandom_range(0, 31);
         if (b == 0) b = 32'd3;
         if (pick == 3) run_sqrt(a >> $urandom_range(0, 31));
         else run_div(a, b, uns, rem, slow, uns ? "R5 random unsigned" : "R6 random signed");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule